// File: doc/BRIEF.md
# Nibble-Mode Parallel Register Port

This block sits on the device side of a byte-wide host data port. It turns a stream of host byte writes into accesses to a small internal register file. Every byte the host writes is sampled on a rising clock edge while `host_wr` is high. Bits 7:5 of the byte are a command code. Bit 4 picks a half, either the low or the high nibble of a register. Bits 3:0 carry a register index or a 4-bit data value. Register contents come back one nibble at a time on status lines 6:3. The host rebuilds a byte by shifting the status value right by three for the low half and left by one for the high half.

A register write goes through the port in this order:
1. End-of-command with the index.
2. Write-address with the index, sent twice.
3. Write-address with the data nibble.
4. The data nibble with bit 6 cleared, sent twice.
5. End-of-command.

The nibble is stored when bit 6 falls. While no command is open, the same port carries bulk packet-buffer data. A data byte with bit 4 clear supplies the low nibble. A following data byte with bit 4 set supplies the high nibble, and the block then emits the finished byte with a one-cycle strobe.

Top module: `nib_reg_port`

## Requirements
- R1: Bits 7:5 of a sampled host byte select the command. 111 is end-of-command, 110 opens a read, 010 opens a write, and 000 is a data byte. The nibble address is bits 4:0: bits 3:0 give the register number, and bit 4 selects the high nibble (bits 7:4) when 1 or the low nibble (bits 3:0) when 0.
- R2: The first write-address byte after the port leaves the write state latches the nibble address. Further write-address bytes, including the one carrying the data value, leave that address unchanged.
- R3: While a write is open, a host byte with bit 6 at 0 that directly follows a host byte with bit 6 at 1 stores its bits 3:0 into the latched nibble. The new contents are readable from the next cycle on. A write stores at most once per fall of bit 6.
- R4: End-of-command closes any open write or read. A later fall of bit 6 stores nothing.
- R5: One cycle after a read-address byte, `host_status` shows the addressed nibble on bits 6:3, with bits 7 and 2:0 at 0.
- R6: `host_status` keeps its value until the next read-address byte, even when the register it came from is rewritten.
- R7: There are REG_COUNT registers of 8 bits each (default 15, numbered 0 to 14). Their roles are station address 0–5, transmit count 6–7, transmit status 8, receive status 9, interrupt status 10, interrupt mask 11, command 12, command 13 and mode 14. For a register number of REG_COUNT or more, writes are discarded and reads return 0.
- R8: With no command open, a data byte with bit 4 at 0 stores its bits 3:0 as the pending low nibble. A data byte with bit 4 at 1 whose predecessor had bit 4 at 0 drives `buf_byte` = {its bits 3:0, pending low nibble}, with `buf_valid` high for exactly one cycle, one cycle after the byte.
- R9: While a read or a write is open, no `buf_valid` strobe is produced.
- R10: After reset all registers read 0, `host_status` is 0, `buf_valid` is 0 and no command is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host byte write strobe, one byte per cycle while high |
| host_data | input | 8 | Host data port byte |
| host_status | output | 8 | Readback status lines, nibble on bits 6:3 |
| buf_byte | output | 8 | Assembled packet-buffer byte |
| buf_valid | output | 1 | One-cycle strobe marking a new `buf_byte` |

## Verification
Every result of this block is due exactly one clock after the host byte that causes it. This covers the stored nibble, the status readback and the bulk strobe, because each path passes through a single register. The bench drives each byte on a falling edge and samples on the following falling edge, half a cycle after the capturing rising edge. A one-cycle strobe is therefore seen exactly once. A free-running monitor counts every `buf_valid` cycle, and that total is compared with the number of bulk bytes the bench expects. This catches strobes that appear during open commands or after a repeated high nibble.

// File: rtl/nib_port_pkg.sv
package nib_port_pkg;

    localparam int NIB_W      = 4;
    localparam int BYTE_W     = 2 * NIB_W;
    localparam int IDX_W      = 4;
    localparam int CMD_LSB    = 5;
    localparam int PHASE_BIT  = 6;
    localparam int HALF_BIT   = 4;
    localparam int STATUS_LSB = 3;

    localparam logic [2:0] CODE_DATA  = 3'b000;
    localparam logic [2:0] CODE_WADDR = 3'b010;
    localparam logic [2:0] CODE_RADDR = 3'b110;
    localparam logic [2:0] CODE_END   = 3'b111;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_WRITE,
        PS_READ
    } port_state_e;

    typedef enum logic [2:0] {
        CK_DATA,
        CK_WADDR,
        CK_RADDR,
        CK_END,
        CK_OTHER
    } cmd_kind_e;

    typedef struct packed {
        logic             hi;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    typedef struct packed {
        logic             en;
        reg_sel_t         sel;
        logic [NIB_W-1:0] nib;
    } nib_write_t;

    typedef struct packed {
        logic     en;
        reg_sel_t sel;
    } nib_read_t;

    typedef struct packed {
        logic             load_lo;
        logic             push;
        logic [NIB_W-1:0] nib;
    } bulk_op_t;

    function automatic cmd_kind_e classify(input logic [BYTE_W-1:0] b);
        cmd_kind_e k;
        case (b[BYTE_W-1:CMD_LSB])
            CODE_DATA:  k = CK_DATA;
            CODE_WADDR: k = CK_WADDR;
            CODE_RADDR: k = CK_RADDR;
            CODE_END:   k = CK_END;
            default:    k = CK_OTHER;
        endcase
        return k;
    endfunction

    function automatic reg_sel_t sel_of(input logic [BYTE_W-1:0] b);
        reg_sel_t s;
        s.hi  = b[HALF_BIT];
        s.idx = b[IDX_W-1:0];
        return s;
    endfunction

    function automatic logic [NIB_W-1:0] pick_nib(input logic [BYTE_W-1:0] v,
                                                  input logic hi);
        return hi ? v[BYTE_W-1:NIB_W] : v[NIB_W-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] status_of(input logic [NIB_W-1:0] n);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[STATUS_LSB +: NIB_W] = n;
        return s;
    endfunction

endpackage

// File: rtl/nib_cmd_decode.sv
module nib_cmd_decode
    import nib_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_data,
    output nib_write_t        wr_op,
    output nib_read_t         rd_op,
    output bulk_op_t          bulk_op
);

    port_state_e state_q;
    reg_sel_t    wr_sel_q;
    logic        prev_half_q;
    logic        prev_phase_q;
    cmd_kind_e   kind;

    assign kind = classify(host_data);

    always_comb begin
        wr_op.en  = host_wr && (state_q == PS_WRITE) && prev_phase_q
                    && !host_data[PHASE_BIT];
        wr_op.sel = wr_sel_q;
        wr_op.nib = host_data[NIB_W-1:0];

        rd_op.en  = host_wr && (kind == CK_RADDR);
        rd_op.sel = sel_of(host_data);

        bulk_op.load_lo = host_wr && (state_q == PS_IDLE) && (kind == CK_DATA)
                          && !host_data[HALF_BIT];
        bulk_op.push    = host_wr && (state_q == PS_IDLE) && (kind == CK_DATA)
                          && host_data[HALF_BIT] && !prev_half_q;
        bulk_op.nib     = host_data[NIB_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= PS_IDLE;
            wr_sel_q     <= '0;
            prev_half_q  <= 1'b0;
            prev_phase_q <= 1'b0;
        end else if (host_wr) begin
            prev_half_q  <= host_data[HALF_BIT];
            prev_phase_q <= host_data[PHASE_BIT];
            case (kind)
                CK_END:   state_q <= PS_IDLE;
                CK_RADDR: state_q <= PS_READ;
                CK_WADDR: begin
                    if (state_q != PS_WRITE) begin
                        state_q  <= PS_WRITE;
                        wr_sel_q <= sel_of(host_data);
                    end
                end
                default: ;
            endcase
        end
    end

    // R4: once the command is closed, the next byte can store nothing
    a_r4_end_blocks_store: assert property (@(posedge clk) disable iff (rst)
        (host_wr && classify(host_data) == CK_END) |=> !wr_op.en);

    // R9: a store, a read and a bulk push never coincide
    a_r9_ops_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_op.en, rd_op.en, bulk_op.push}));

    // R2: a repeated write-address byte keeps the latched address
    a_r2_addr_held: assert property (@(posedge clk) disable iff (rst)
        (host_wr && state_q == PS_WRITE && classify(host_data) == CK_WADDR)
        |=> $stable(wr_sel_q));

endmodule

// File: rtl/nib_reg_file.sv
module nib_reg_file
    import nib_port_pkg::*;
#(
    parameter int REG_COUNT = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  nib_write_t        wr_op,
    input  nib_read_t         rd_op,
    output logic [BYTE_W-1:0] status
);

    logic [BYTE_W-1:0] regs_q [REG_COUNT];
    logic [BYTE_W-1:0] rd_byte;
    logic [BYTE_W-1:0] status_q;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (wr_op.en && wr_op.sel.idx == IDX_W'(g)) begin
                if (wr_op.sel.hi) regs_q[g][BYTE_W-1:NIB_W] <= wr_op.nib;
                else              regs_q[g][NIB_W-1:0]      <= wr_op.nib;
            end
        end

        // R7: a store touches only the register it addresses
        a_r7_only_target: assert property (@(posedge clk) disable iff (rst)
            (wr_op.en && wr_op.sel.idx != IDX_W'(g)) |=> $stable(regs_q[g]));
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (rd_op.sel.idx == IDX_W'(i)) rd_byte = regs_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            status_q <= '0;
        else if (rd_op.en)  status_q <= status_of(pick_nib(rd_byte, rd_op.sel.hi));
    end

    assign status = status_q;

    // R6: status changes only after a read-address byte
    a_r6_status_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_op.en |=> $stable(status_q));

endmodule

// File: rtl/nib_byte_pack.sv
module nib_byte_pack
    import nib_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bulk_op_t          bulk_op,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_valid
);

    logic [NIB_W-1:0]  lo_q;
    logic [BYTE_W-1:0] byte_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            byte_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= bulk_op.push;
            if (bulk_op.load_lo) lo_q <= bulk_op.nib;
            if (bulk_op.push)    byte_q <= {bulk_op.nib, lo_q};
        end
    end

    assign out_byte  = byte_q;
    assign out_valid = valid_q;

    // R8: the completion strobe lasts a single cycle
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

endmodule

// File: rtl/nib_reg_port.sv
module nib_reg_port
    import nib_port_pkg::*;
#(
    parameter int REG_COUNT = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic [7:0] host_data,
    output logic [7:0] host_status,
    output logic [7:0] buf_byte,
    output logic       buf_valid
);

    nib_write_t wr_op;
    nib_read_t  rd_op;
    bulk_op_t   bulk_op;

    nib_cmd_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .host_wr   (host_wr),
        .host_data (host_data),
        .wr_op     (wr_op),
        .rd_op     (rd_op),
        .bulk_op   (bulk_op)
    );

    nib_reg_file #(.REG_COUNT(REG_COUNT)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_op  (wr_op),
        .rd_op  (rd_op),
        .status (host_status)
    );

    nib_byte_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .bulk_op   (bulk_op),
        .out_byte  (buf_byte),
        .out_valid (buf_valid)
    );

endmodule

// File: tb/nib_reg_port_test.sv
`timescale 1ns/1ps
module nib_reg_port_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr;
    logic [7:0] host_data;
    logic [7:0] host_status;
    logic [7:0] buf_byte;
    logic       buf_valid;

    int vectors = 0;
    int errors  = 0;
    int strobes_seen = 0;
    int strobes_exp  = 0;
    logic [7:0] model [16];

    always #2.5 clk = ~clk;

    nib_reg_port uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_data(host_data),
        .host_status(host_status), .buf_byte(buf_byte), .buf_valid(buf_valid)
    );

    always @(negedge clk) if (!rst && buf_valid) strobes_seen++;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        host_wr   = 1'b1;
        host_data = b;
        @(negedge clk);
        host_wr   = 1'b0;
    endtask

    function automatic logic [7:0] exp_status(input logic [4:0] a);
        logic [3:0] n;
        if (a[3:0] >= 4'd15) n = 4'h0;
        else n = a[4] ? model[a[3:0]][7:4] : model[a[3:0]][3:0];
        return {1'b0, n, 3'b000};
    endfunction

    task automatic write_nib(input logic [4:0] a, input logic [3:0] v);
        logic [7:0] hv;
        hv = {3'b000, a[4], v};
        send(8'hE0 | 8'(a));
        send(8'h40 | 8'(a));
        send(8'h40 | 8'(a));
        send(8'h40 | hv);
        send(hv);
        send(hv);
        send(8'hE0 | hv);
        if (a[3:0] < 4'd15) begin
            if (a[4]) model[a[3:0]][7:4] = v;
            else      model[a[3:0]][3:0] = v;
        end
    endtask

    task automatic read_chk(input string req, input logic [4:0] a);
        send(8'hE0 | 8'(a));
        send(8'hC0 | 8'(a));
        chk(req, host_status, exp_status(a));
        send(8'hE0 | 8'(a));
    endtask

    task automatic bulk(input logic [7:0] v);
        send({4'h0, v[3:0]});
        send({4'h1, v[7:4]});
        strobes_exp++;
        chk("R8 strobe", {7'd0, buf_valid}, 8'd1);
        chk("R8 byte", buf_byte, v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [7:0] held;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        rst = 1'b1; host_wr = 1'b0; host_data = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        chk("R10 status", host_status, 8'h00);
        chk("R10 valid", {7'd0, buf_valid}, 8'd0);
        for (int r = 0; r < 16; r++)
            for (int h = 0; h < 2; h++)
                read_chk("R10 reg", {h[0], r[3:0]});

        // R1 R3 R5 R7: nibble write sweep, two passes, readback of all halves
        for (int p = 0; p < 2; p++) begin
            for (int r = 0; r < 16; r++)
                for (int h = 0; h < 2; h++)
                    write_nib({h[0], r[3:0]}, 4'((r * 5 + h * 11 + p * 7 + 3) % 16));
            for (int r = 0; r < 16; r++)
                for (int h = 0; h < 2; h++)
                    read_chk((r == 15) ? "R7 out of range" : "R1 R3 R5 readback",
                             {h[0], r[3:0]});
        end

        // R2: a differing write-address byte mid-command does not move the address
        write_nib(5'h09, 4'h4);
        send(8'hE6); send(8'h46); send(8'h49); send(8'h41); send(8'h01); send(8'hE1);
        model[6][3:0] = 4'h1;
        read_chk("R2 target", 5'h06);
        read_chk("R2 other", 5'h09);

        // R4: fall of bit 6 after end-of-command stores nothing
        write_nib(5'h03, 4'h5);
        send(8'hE3); send(8'h43); send(8'h4A); send(8'hE0); send(8'h0A);
        read_chk("R4 closed", 5'h03);

        // R8: exhaustive bulk bytes
        for (int v = 0; v < 256; v++) bulk(8'(v));
        @(negedge clk);
        chk("R8 pulse width", {7'd0, buf_valid}, 8'd0);

        // R8: repeated high nibble does not produce a second byte
        bulk(8'h53);
        send(8'h17);
        chk("R8 repeat high", {7'd0, buf_valid}, 8'd0);

        // R9: no strobe while a read is open
        send(8'hC2); send(8'h06); send(8'h19);
        chk("R9 read open", {7'd0, buf_valid}, 8'd0);
        send(8'hE0);
        // R9: no strobe while a write is open (the 0x07 byte stores into reg 2 low)
        send(8'hE2); send(8'h42); send(8'h42); send(8'h07); send(8'h18);
        chk("R9 write open", {7'd0, buf_valid}, 8'd0);
        send(8'hE0);
        model[2][3:0] = 4'h7;
        read_chk("R3 single store", 5'h02);

        // R6: status keeps its value across bulk traffic and a rewrite of its source
        write_nib(5'h04, 4'hC);
        send(8'hE4); send(8'hC4);
        held = host_status;
        chk("R5 snapshot", held, 8'h60);
        send(8'hE4);
        bulk(8'h5A);
        write_nib(5'h04, 4'h2);
        chk("R6 hold", host_status, held);
        read_chk("R6 new read", 5'h04);

        @(negedge clk);
        chk("R9 strobe count", 8'(strobes_seen), 8'(strobes_exp));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule